// File: doc/BRIEF.md
# Multi-Capture High-Dynamic-Range Pixel Combiner

This block turns a burst of non-destructive readings of a single pixel into one wide-range value. Within one output frame the pixel is read several times at exposures that double from one reading to the next (T, 2T, 4T and so on up to 32T with the default of six readings). Each reading is an 8-bit sample.

The combiner works recursively and needs very little state. It keeps one running estimate: the most recent usable sample and the capture index it came from. A later sample replaces the estimate only while the pixel is still trustworthy. A sample that reaches the saturation threshold freezes the estimate. So does a sample that departs too far from what the current estimate predicts, which points to motion in the scene. After the last reading of the frame, the kept sample is scaled up to the longest exposure by a left shift, and the result is presented together with a code that gives the reason processing stopped. One result is produced per frame, while readings arrive at the much higher capture rate.

Top module: `hdr_combiner`

## Requirements
- R1: While and after reset, and before any result, `hdr_valid` is 0, `hdr_value` is 0 and `hdr_stop` is 00.
- R2: `hdr_valid` pulses high for exactly one cycle, in the cycle after the clock edge that accepts a valid sample with index 5 (the last capture). In no other cycle is it high.
- R3: A sample with value at or above `cfg_sat_thr` counts as saturated. It stops updating, and `hdr_stop` becomes 01 (saturation). The result is the last unsaturated sample shifted left by (5 minus its capture index).
- R4: If the index-0 sample is already saturated, the result is that sample multiplied by 32, with `hdr_stop` = 01.
- R5: If no stop occurs in a frame, the result is the index-5 sample unshifted, with `hdr_stop` = 00.
- R6: Motion is a non-saturated sample whose absolute difference from twice the current estimate exceeds `cfg_motion_tol`. It stops updating and gives `hdr_stop` = 10. The result is the previous estimate scaled by its own exposure ratio.
- R7: A difference exactly equal to `cfg_motion_tol` is not motion, and the sample becomes the new estimate.
- R8: A sample that is both saturated and off-prediction is reported as saturation (01).
- R9: Once a frame has stopped, its later samples have no effect on the result or on the stop code.
- R10: A valid sample with index 0 always starts a fresh frame and discards any unfinished frame.
- R11: `hdr_value` and `hdr_stop` keep their values between result pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sat_thr | input | 8 | Saturation threshold (typically 250) |
| cfg_motion_tol | input | 8 | Allowed deviation from the predicted sample |
| smp_valid | input | 1 | Sample present this cycle |
| smp_idx | input | 3 | Capture index 0..5, exposure 2^idx·T |
| smp_val | input | 8 | Pixel sample |
| hdr_valid | output | 1 | One-cycle result strobe |
| hdr_value | output | 13 | Combined value at the 32T scale |
| hdr_stop | output | 2 | 00 no stop, 01 saturation, 10 motion |

## Verification
The assertions assume that captures of a frame arrive in rising index order, starting at 0 and never above 5. They also assume that the threshold and tolerance are held constant for a whole frame, so that a zero-stop result can be compared with the threshold. The bench drives every frame as a complete ordered burst of indices 0 through 5 and changes the configuration only between frames. One exception is a deliberately abandoned partial frame, which is cut short by a new index-0 sample and never reaches index 5.

// File: rtl/hdr_pkg.sv
package hdr_pkg;
    typedef enum logic [1:0] {
        STOP_NONE   = 2'b00,
        STOP_SAT    = 2'b01,
        STOP_MOTION = 2'b10
    } stop_e;
endpackage

// File: rtl/hdr_sample_judge.sv
module hdr_sample_judge #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] sample,
    input  logic [PIX_W-1:0] est,
    input  logic [PIX_W-1:0] thr,
    input  logic [PIX_W-1:0] tol,
    output logic             is_sat,
    output logic             is_motion
);
    localparam int EXT_W = PIX_W + 1;

    logic [EXT_W-1:0] pred;
    logic [EXT_W-1:0] samp_ext;
    logic [EXT_W-1:0] gap;

    always_comb begin
        pred     = {est, 1'b0};
        samp_ext = {1'b0, sample};
        gap      = (samp_ext > pred) ? (samp_ext - pred) : (pred - samp_ext);
        is_sat    = (sample >= thr);
        is_motion = (gap > {1'b0, tol});
    end
endmodule

// File: rtl/hdr_exposure_scaler.sv
module hdr_exposure_scaler #(
    parameter int PIX_W    = 8,
    parameter int NUM_CAPT = 6,
    parameter int IDX_W    = 3,
    parameter int OUT_W    = PIX_W + NUM_CAPT - 1
) (
    input  logic [PIX_W-1:0] val,
    input  logic [IDX_W-1:0] idx,
    output logic [OUT_W-1:0] scaled
);
    localparam int LAST = NUM_CAPT - 1;

    logic [OUT_W-1:0] cand [NUM_CAPT];

    for (genvar g = 0; g < NUM_CAPT; g++) begin : g_shift
        assign cand[g] = OUT_W'(val) << (LAST - g);
    end

    always_comb begin
        scaled = '0;
        for (int k = 0; k < NUM_CAPT; k++) begin
            if (idx == IDX_W'(k)) scaled = cand[k];
        end
    end
endmodule

// File: rtl/hdr_combiner.sv
module hdr_combiner #(
    parameter int PIX_W    = 8,
    parameter int NUM_CAPT = 6,
    parameter int IDX_W    = (NUM_CAPT > 1) ? $clog2(NUM_CAPT) : 1,
    parameter int OUT_W    = PIX_W + NUM_CAPT - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] cfg_sat_thr,
    input  logic [PIX_W-1:0] cfg_motion_tol,
    input  logic             smp_valid,
    input  logic [IDX_W-1:0] smp_idx,
    input  logic [PIX_W-1:0] smp_val,
    output logic             hdr_valid,
    output logic [OUT_W-1:0] hdr_value,
    output logic [1:0]       hdr_stop
);
    import hdr_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CAPT - 1);

    typedef struct packed {
        logic             active;
        stop_e            stop;
        logic [PIX_W-1:0] est;
        logic [IDX_W-1:0] pick;
        logic             out_vld;
        logic [OUT_W-1:0] out_val;
        stop_e            out_stop;
    } state_t;

    state_t state_d, state_q;

    logic             is_sat, is_motion;
    logic             take_first, take_later, frame_end;
    logic [PIX_W-1:0] est_nx;
    logic [IDX_W-1:0] pick_nx;
    stop_e            stop_nx;
    logic [OUT_W-1:0] scaled;

    hdr_sample_judge #(.PIX_W(PIX_W)) u_judge (
        .sample   (smp_val),
        .est      (state_q.est),
        .thr      (cfg_sat_thr),
        .tol      (cfg_motion_tol),
        .is_sat   (is_sat),
        .is_motion(is_motion)
    );

    // Estimate update for the current sample.
    always_comb begin
        take_first = smp_valid && (smp_idx == '0);
        take_later = smp_valid && (smp_idx != '0) && state_q.active;
        frame_end  = (take_first || take_later) && (smp_idx == LAST_IDX);
        est_nx     = state_q.est;
        pick_nx    = state_q.pick;
        stop_nx    = state_q.stop;
        if (take_first) begin
            est_nx  = smp_val;
            pick_nx = '0;
            stop_nx = is_sat ? STOP_SAT : STOP_NONE;
        end else if (take_later && state_q.stop == STOP_NONE) begin
            if (is_sat) begin
                stop_nx = STOP_SAT;
            end else if (is_motion) begin
                stop_nx = STOP_MOTION;
            end else begin
                est_nx  = smp_val;
                pick_nx = smp_idx;
            end
        end
    end

    hdr_exposure_scaler #(
        .PIX_W   (PIX_W),
        .NUM_CAPT(NUM_CAPT),
        .IDX_W   (IDX_W),
        .OUT_W   (OUT_W)
    ) u_scale (
        .val   (est_nx),
        .idx   (pick_nx),
        .scaled(scaled)
    );

    always_comb begin
        state_d         = state_q;
        state_d.out_vld = 1'b0;
        state_d.est     = est_nx;
        state_d.pick    = pick_nx;
        state_d.stop    = stop_nx;
        if (take_first) state_d.active = 1'b1;
        if (frame_end) begin
            state_d.active   = 1'b0;
            state_d.out_vld  = 1'b1;
            state_d.out_val  = scaled;
            state_d.out_stop = stop_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{active: 1'b0, stop: STOP_NONE, est: '0, pick: '0,
                         out_vld: 1'b0, out_val: '0, out_stop: STOP_NONE};
        end else begin
            state_q <= state_d;
        end
    end

    assign hdr_valid = state_q.out_vld;
    assign hdr_value = state_q.out_val;
    assign hdr_stop  = state_q.out_stop;
endmodule

// File: rtl/hdr_combiner_chk.sv
module hdr_combiner_chk #(
    parameter int PIX_W    = 8,
    parameter int NUM_CAPT = 6,
    parameter int IDX_W    = 3,
    parameter int OUT_W    = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PIX_W-1:0] cfg_sat_thr,
    input logic             smp_valid,
    input logic [IDX_W-1:0] smp_idx,
    input logic             hdr_valid,
    input logic [OUT_W-1:0] hdr_value,
    input logic [1:0]       hdr_stop
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CAPT - 1);

    logic seen_rst;
    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst <= 1'b1;
        else if (seen_rst) seen_rst <= 1'b1;
        else seen_rst <= 1'b0;
    end

    AST_RESULT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_idx == LAST_IDX) |=> hdr_valid); // R2
    AST_NO_STRAY_PULSE: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
        !(smp_valid && smp_idx == LAST_IDX) |=> !hdr_valid); // R2
    AST_OUTPUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
        !hdr_valid |-> ($stable(hdr_value) && $stable(hdr_stop))); // R11
    AST_STOP_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_stop != 2'b11); // R6
    AST_NOSTOP_BELOW_THR: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_stop == 2'b00) |-> (hdr_value < OUT_W'(cfg_sat_thr))); // R5
    AST_STOP_SCALED_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_stop != 2'b00) |-> (hdr_value[0] == 1'b0)); // R3
endmodule

bind hdr_combiner hdr_combiner_chk #(
    .PIX_W   (PIX_W),
    .NUM_CAPT(NUM_CAPT),
    .IDX_W   (IDX_W),
    .OUT_W   (OUT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_sat_thr(cfg_sat_thr),
    .smp_valid  (smp_valid),
    .smp_idx    (smp_idx),
    .hdr_valid  (hdr_valid),
    .hdr_value  (hdr_value),
    .hdr_stop   (hdr_stop)
);

// File: tb/hdr_combiner_bench.sv
module hdr_combiner_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_sat_thr = 8'd250;
    logic [7:0]  cfg_motion_tol = 8'd0;
    logic        smp_valid = 1'b0;
    logic [2:0]  smp_idx = '0;
    logic [7:0]  smp_val = '0;
    logic        hdr_valid;
    logic [12:0] hdr_value;
    logic [1:0]  hdr_stop;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int fr [6];

    always #2 clk = ~clk;

    hdr_combiner u_hdr_combiner (
        .clk(clk), .rst_n(rst_n), .cfg_sat_thr(cfg_sat_thr),
        .cfg_motion_tol(cfg_motion_tol), .smp_valid(smp_valid),
        .smp_idx(smp_idx), .smp_val(smp_val), .hdr_valid(hdr_valid),
        .hdr_value(hdr_value), .hdr_stop(hdr_stop)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drives fr[0..5] on consecutive cycles, then checks the result pulse.
    task automatic run_frame(input string req, input int exp_val, input int exp_stop);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            smp_idx   = 3'(k);
            smp_val   = 8'(fr[k]);
            if (k > 0) chk({req, " R2 no early pulse"}, int'(hdr_valid), 0);
        end
        @(negedge clk);
        smp_valid = 1'b0;
        chk({req, " R2 pulse"}, int'(hdr_valid), 1);
        chk({req, " value"}, int'(hdr_value), exp_val);
        chk({req, " stop"}, int'(hdr_stop), exp_stop);
        @(negedge clk);
        chk("R2 pulse ends", int'(hdr_valid), 0);
        chk("R11 value held", int'(hdr_value), exp_val);
        chk("R11 stop held", int'(hdr_stop), exp_stop);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid", int'(hdr_valid), 0);
        chk("R1 value", int'(hdr_value), 0);
        chk("R1 stop", int'(hdr_stop), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", int'(hdr_valid), 0);

        // Ideal pixel: samples double each capture, clipped at 255.
        foreach (fr[i]) fr[i] = 0;
        for (int t = 0; t < 4; t++) begin
            cfg_sat_thr    = (t == 0) ? 8'd250 : (t == 1) ? 8'd100 : (t == 2) ? 8'd16 : 8'd0;
            cfg_motion_tol = 8'd0;
            for (int f = 0; f < 256; f++) begin
                for (int k = 0; k < 6; k++) fr[k] = ((f << k) > 255) ? 255 : (f << k);
                if (f * 32 < int'(cfg_sat_thr))
                    run_frame("R5 ideal no stop", f * 32, 0);
                else if (f >= int'(cfg_sat_thr))
                    run_frame("R4 first saturated", f * 32, 1);
                else
                    run_frame("R3 saturation", f * 32, 1);
            end
        end

        // Motion steps with base 3: ideal 3,6,12,24,48,96.
        cfg_sat_thr = 8'd255;
        for (int t = 0; t < 3; t++) begin
            cfg_motion_tol = (t == 0) ? 8'd0 : (t == 1) ? 8'd2 : 8'd5;
            for (int m = 1; m < 6; m++) begin
                for (int sgn = 0; sgn < 2; sgn++) begin
                    int d;
                    d = (sgn == 0) ? (int'(cfg_motion_tol) + 1) : -(int'(cfg_motion_tol) + 1);
                    for (int k = 0; k < 6; k++) fr[k] = 3 << k;
                    fr[m] = (3 << m) + d;
                    run_frame("R6 motion", 96, 2);
                    for (int k = m + 1; k < 6; k++) fr[k] = 254;
                    run_frame("R9 ignored after stop", 96, 2);
                    d = (sgn == 0) ? int'(cfg_motion_tol) : -int'(cfg_motion_tol);
                    for (int k = 0; k < 6; k++) fr[k] = 3 << k;
                    for (int k = m; k < 6; k++) fr[k] = ((3 << m) + d) << (k - m);
                    run_frame("R7 tolerance edge", ((3 << m) + d) << (5 - m), 0);
                end
            end
        end

        // Saturated and off-prediction at once.
        cfg_sat_thr    = 8'd100;
        cfg_motion_tol = 8'd1;
        for (int m = 1; m < 6; m++) begin
            for (int k = 0; k < 6; k++) fr[k] = 3 << k;
            fr[m] = 200;
            run_frame("R8 saturation wins", 96, 1);
        end

        // Abandoned partial frame, then a fresh one.
        cfg_sat_thr    = 8'd250;
        cfg_motion_tol = 8'd0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            smp_idx   = 3'(k);
            smp_val   = 8'd255;
        end
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R10 no pulse for partial", int'(hdr_valid), 0);
        for (int k = 0; k < 6; k++) fr[k] = 5 << k;
        run_frame("R10 fresh frame", 160, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule